// File: doc/BRIEF.md
# Floating-Point Mode Resolver with Accuracy Field

This block keeps the floating-point control register of a core: sticky exception flags, a dynamic rounding mode and a two-bit accuracy mode. On each issued floating-point operation it combines the rounding field carried by the instruction with the stored dynamic rounding mode to give the effective rounding mode. It also reports the stored accuracy mode. In the same cycle it flags the operation as illegal when the rounding mode is reserved or when hardware cannot run the pair of accuracy mode and opcode class. Software can then emulate the operation in its trap handler.

Software reaches the register through a small select-coded port. The port gives access to the whole register, to the flags alone or to the rounding mode alone, and all three views share the same storage. Completing operations report their exception flags, and the block ORs those flags into the sticky field. The table of supported pairs is an elaboration parameter, so one design can serve cores with different amounts of reduced-accuracy hardware.

Top module: `fpmode_unit`

## Requirements
- R1: After reset the full register reads as zero: flags 00000, rounding mode 000 and accuracy mode 00 (the strict IEEE 754 mode).
- R2: An issued operation whose rounding field is 000 to 100 gets that value as its effective rounding mode, whatever the stored rounding mode holds. The operation is legal when its pair is supported.
- R3: A rounding field of 111 selects the stored rounding mode. If the stored rounding mode is 101, 110 or 111, the operation is illegal.
- R4: A rounding field of 101 or 110 in the instruction is reserved, and the operation is illegal.
- R5: The effective accuracy mode is the stored accuracy field. Accuracy mode 00 is legal for every opcode class below N_CLASS, whatever the support table holds.
- R6: For accuracy modes 01 to 11, the operation is illegal when bit [mode*N_CLASS+class] of SUPPORT is 0. A class index at or above N_CLASS is always illegal. iss_illegal is high only while iss_valid is high.
- R7: With csr_sel=11, the register reads as {zeros, accuracy[9:8], rounding[7:5], flags[4:0]}. A write loads those three fields from the same bit positions. Bits above 9 read as zero and writes to them are ignored.
- R8: The select codes work as follows:
  - csr_sel=01 reads and writes only the flags, at bits [4:0].
  - csr_sel=10 reads and writes only the rounding mode, at bits [2:0].
  - An alias write leaves the other fields unchanged.
  - csr_sel=00 reads zero, and a write with it changes nothing.
  - A write takes effect on the next cycle.
- R9: A done_valid pulse ORs done_flags into the sticky flags. When a flags write (csr_sel 01 or 11) happens in the same cycle, the new flags are the written value ORed with done_flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | View select: 00 none, 01 flags, 10 rounding, 11 full |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Read data of the selected view (combinational) |
| iss_valid | input | 1 | A floating-point operation is issued this cycle |
| iss_rm | input | 3 | Rounding field of the instruction (111 = dynamic) |
| iss_cls | input | CLS_W | Opcode class of the operation |
| iss_illegal | output | 1 | Operation must trap (combinational) |
| eff_rm | output | 3 | Effective rounding mode |
| eff_acc | output | 2 | Effective accuracy mode |
| done_valid | input | 1 | Datapath completion with flags |
| done_flags | input | 5 | Exception flags of the completed operation |

## Verification
The bench builds the block with N_CLASS=5. A three-bit class field then carries the codes 5 to 7, which name no class, so the out-of-range path of R6 can be reached. SUPPORT is set to 20'hA047F:
- Mode 01 supports classes 0 and 1.
- Mode 10 supports class 0.
- Mode 11 supports classes 2 and 4.
- The mode 00 row is all ones.

This mix puts supported and unsupported pairs in every reduced mode and leaves gaps that are not contiguous. Every rounding field is swept against every class code, and every stored rounding value is tried under dynamic selection.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;
  localparam int FLG_W = 5;
  localparam int RM_W  = 3;
  localparam int ACC_W = 2;
  localparam int REG_W = FLG_W + RM_W + ACC_W;

  localparam logic [RM_W-1:0] RM_DYN   = 3'b111;
  localparam logic [RM_W-1:0] RM_LIMIT = 3'd4;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'b00,
    SEL_FLAGS = 2'b01,
    SEL_RM    = 2'b10,
    SEL_ALL   = 2'b11
  } csr_sel_e;

  typedef struct packed {
    logic [ACC_W-1:0] acc;
    logic [RM_W-1:0]  frm;
    logic [FLG_W-1:0] flags;
  } fcr_t;

  function automatic logic rm_is_valid(input logic [RM_W-1:0] rm);
    return rm <= RM_LIMIT;
  endfunction

  function automatic logic [RM_W-1:0] pick_rm(input logic [RM_W-1:0] inst_rm,
                                              input logic [RM_W-1:0] dyn_rm);
    return (inst_rm == RM_DYN) ? dyn_rm : inst_rm;
  endfunction
endpackage

// File: rtl/fpm_csr.sv
`timescale 1ns/1ps
module fpm_csr
  import fpm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              done_valid,
  input  logic [FLG_W-1:0]  done_flags,
  output fcr_t              cur
);
  csr_sel_e sel;
  fcr_t     state_q, state_d;
  logic     wr_flags, wr_rm, wr_acc, acc_evt;

  assign sel      = csr_sel_e'(csr_sel);
  assign wr_flags = csr_we && (sel == SEL_FLAGS || sel == SEL_ALL);
  assign wr_rm    = csr_we && (sel == SEL_RM || sel == SEL_ALL);
  assign wr_acc   = csr_we && (sel == SEL_ALL);
  assign acc_evt  = done_valid && (|done_flags);

  always_comb begin
    state_d = state_q;
    if (wr_flags) state_d.flags = csr_wdata[FLG_W-1:0];
    if (wr_rm)
      state_d.frm = (sel == SEL_ALL) ? csr_wdata[FLG_W +: RM_W] : csr_wdata[RM_W-1:0];
    if (wr_acc) state_d.acc = csr_wdata[FLG_W+RM_W +: ACC_W];
    if (acc_evt) state_d.flags = state_d.flags | done_flags;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  always_comb begin
    case (sel)
      SEL_FLAGS: csr_rdata = DATA_W'(state_q.flags);
      SEL_RM:    csr_rdata = DATA_W'(state_q.frm);
      SEL_ALL:   csr_rdata = DATA_W'(state_q);
      default:   csr_rdata = '0;
    endcase
  end

  assign cur = state_q;

  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flags |=> ((state_q.flags & $past(state_q.flags)) == $past(state_q.flags))); // R9
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata >> REG_W) == '0); // R7
  AST_FLAG_ALIAS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && sel == SEL_FLAGS) |=> (state_q.frm == $past(state_q.frm) &&
                                      state_q.acc == $past(state_q.acc))); // R8
  AST_RM_ALIAS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && sel == SEL_RM && !done_valid) |=>
      (state_q.flags == $past(state_q.flags) && state_q.acc == $past(state_q.acc))); // R8
endmodule

// File: rtl/fpm_resolve.sv
`timescale 1ns/1ps
module fpm_resolve
  import fpm_pkg::*;
#(
  parameter int                 N_CLASS = 4,
  parameter int                 CLS_W   = 2,
  parameter logic [4*N_CLASS-1:0] SUPPORT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [RM_W-1:0]  iss_rm,
  input  logic [CLS_W-1:0] iss_cls,
  input  logic [RM_W-1:0]  cur_frm,
  input  logic [ACC_W-1:0] cur_acc,
  output logic             iss_illegal,
  output logic [RM_W-1:0]  eff_rm,
  output logic [ACC_W-1:0] eff_acc
);
  function automatic logic pair_ok(input logic [ACC_W-1:0] acc, input logic [CLS_W-1:0] cls);
    logic ok;
    ok = 1'b0;
    for (int c = 0; c < N_CLASS; c++) begin
      if (cls == CLS_W'(c)) ok = (acc == '0) || SUPPORT[int'(acc) * N_CLASS + c];
    end
    return ok;
  endfunction

  logic dyn_sel, rm_bad, pair_bad;

  assign dyn_sel     = (iss_rm == RM_DYN);
  assign eff_rm      = pick_rm(iss_rm, cur_frm);
  assign eff_acc     = cur_acc;
  assign rm_bad      = !rm_is_valid(eff_rm);
  assign pair_bad    = !pair_ok(cur_acc, iss_cls);
  assign iss_illegal = iss_valid && (rm_bad || pair_bad);

  AST_DYN_BAD_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && dyn_sel && cur_frm > RM_LIMIT) |-> iss_illegal); // R3
  AST_STATIC_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (iss_rm == 3'b101 || iss_rm == 3'b110)) |-> iss_illegal); // R4
  AST_STATIC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_rm <= RM_LIMIT && cur_acc == '0 && iss_cls == '0) |->
      (!iss_illegal && eff_rm == iss_rm)); // R2
  AST_ILLEGAL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    iss_illegal |-> iss_valid); // R6
endmodule

// File: rtl/fpmode_unit.sv
`timescale 1ns/1ps
module fpmode_unit
  import fpm_pkg::*;
#(
  parameter int                   N_CLASS = 4,
  parameter logic [4*N_CLASS-1:0] SUPPORT = 16'h413F,
  parameter int                   DATA_W  = 32,
  localparam int                  CLS_W   = (N_CLASS > 1) ? $clog2(N_CLASS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic              iss_valid,
  input  logic [2:0]        iss_rm,
  input  logic [CLS_W-1:0]  iss_cls,
  output logic              iss_illegal,
  output logic [2:0]        eff_rm,
  output logic [1:0]        eff_acc,
  input  logic              done_valid,
  input  logic [4:0]        done_flags
);
  fcr_t cur;

  fpm_csr #(.DATA_W(DATA_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .done_valid(done_valid), .done_flags(done_flags), .cur(cur)
  );

  fpm_resolve #(.N_CLASS(N_CLASS), .CLS_W(CLS_W), .SUPPORT(SUPPORT)) u_res (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_rm(iss_rm),
    .iss_cls(iss_cls), .cur_frm(cur.frm), .cur_acc(cur.acc),
    .iss_illegal(iss_illegal), .eff_rm(eff_rm), .eff_acc(eff_acc)
  );

  AST_ACC_FOLLOWS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_sel == 2'b11) |=> (eff_acc == $past(csr_wdata[9:8]))); // R5
endmodule

// File: tb/sim_fpmode_unit.sv
`timescale 1ns/1ps
module sim_fpmode_unit;
  localparam int                NC  = 5;
  localparam logic [4*NC-1:0]   SUP = 20'hA047F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = 2'b00;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        iss_valid = 1'b0;
  logic [2:0]  iss_rm = '0;
  logic [2:0]  iss_cls = '0;
  logic        iss_illegal;
  logic [2:0]  eff_rm;
  logic [1:0]  eff_acc;
  logic        done_valid = 1'b0;
  logic [4:0]  done_flags = '0;

  always #4 clk = ~clk;

  fpmode_unit #(.N_CLASS(NC), .SUPPORT(SUP), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .iss_valid(iss_valid),
    .iss_rm(iss_rm), .iss_cls(iss_cls), .iss_illegal(iss_illegal),
    .eff_rm(eff_rm), .eff_acc(eff_acc), .done_valid(done_valid),
    .done_flags(done_flags)
  );

  typedef struct {
    string       tag;
    logic [31:0] rd;
    bit          do_iss;
    bit          ill;
    logic [2:0]  rm;
    logic [1:0]  acc;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done_run = 1'b0;

  logic [4:0] m_flags = '0;
  logic [2:0] m_frm   = '0;
  logic [1:0] m_acc   = '0;

  function automatic logic [31:0] model_read(input logic [1:0] sel);
    case (sel)
      2'b01:   return {27'd0, m_flags};
      2'b10:   return {29'd0, m_frm};
      2'b11:   return {22'd0, m_acc, m_frm, m_flags};
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit model_illegal(input logic [2:0] rm, input logic [2:0] cls);
    logic [2:0] r;
    bit         sup;
    r = (rm == 3'b111) ? m_frm : rm;
    if (int'(cls) >= NC) sup = 1'b0;
    else if (m_acc == 2'b00) sup = 1'b1;
    else sup = SUP[int'(m_acc) * NC + int'(cls)];
    return (r > 3'd4) || !sup;
  endfunction

  task automatic cyc(input string tag, input bit we, input logic [1:0] sel,
                     input logic [31:0] wd, input bit iv, input logic [2:0] rm,
                     input logic [2:0] cls, input bit dv, input logic [4:0] df);
    item_t it;
    @(negedge clk);
    csr_we = we; csr_sel = sel; csr_wdata = wd;
    iss_valid = iv; iss_rm = rm; iss_cls = cls;
    done_valid = dv; done_flags = df;
    it.tag = tag;
    it.rd = model_read(sel);
    it.do_iss = 1'b1;
    it.ill = iv ? model_illegal(rm, cls) : 1'b0;
    it.rm = (rm == 3'b111) ? m_frm : rm;
    it.acc = m_acc;
    q.push_back(it);
    if (we) begin
      case (sel)
        2'b01: m_flags = wd[4:0];
        2'b10: m_frm = wd[2:0];
        2'b11: begin m_flags = wd[4:0]; m_frm = wd[7:5]; m_acc = wd[9:8]; end
        default: ;
      endcase
    end
    if (dv) m_flags = m_flags | df;
  endtask

  task automatic rd(input string tag, input logic [1:0] sel);
    cyc(tag, 1'b0, sel, 32'd0, 1'b0, 3'd0, 3'd0, 1'b0, 5'd0);
  endtask

  task automatic wr(input string tag, input logic [1:0] sel, input logic [31:0] wd);
    cyc(tag, 1'b1, sel, wd, 1'b0, 3'd0, 3'd0, 1'b0, 5'd0);
  endtask

  task automatic iss(input string tag, input logic [2:0] rm, input logic [2:0] cls);
    cyc(tag, 1'b0, 2'b00, 32'd0, 1'b1, rm, cls, 1'b0, 5'd0);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (csr_rdata !== it.rd) begin
          errors++;
          $display("FAIL %s rdata act %h exp %h", it.tag, csr_rdata, it.rd);
        end
        if (it.do_iss) begin
          checks++;
          if (iss_illegal !== it.ill) begin
            errors++;
            $display("FAIL %s illegal act %b exp %b", it.tag, iss_illegal, it.ill);
          end else if (!it.ill && iss_valid && (eff_rm !== it.rm || eff_acc !== it.acc)) begin
            errors++;
            $display("FAIL %s modes act rm %0d acc %0d exp rm %0d acc %0d",
                     it.tag, eff_rm, eff_acc, it.rm, it.acc);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog expired act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd("R1 reset full read", 2'b11);
    rd("R1 reset flags read", 2'b01);

    wr("R7 write all ones", 2'b11, 32'hFFFF_FFFF);
    rd("R7 read after ones", 2'b11);
    wr("R7 write pattern", 2'b11, 32'hFFFF_FD55);
    rd("R7 read pattern", 2'b11);

    wr("R8 flags alias write", 2'b01, 32'hFFFF_FF0A);
    rd("R8 full after flags write", 2'b11);
    wr("R8 rounding alias write", 2'b10, 32'hFFFF_FFFC);
    rd("R8 rounding read", 2'b10);
    rd("R8 flags read", 2'b01);
    rd("R8 full after rounding write", 2'b11);
    wr("R8 none write", 2'b00, 32'hFFFF_FFFF);
    rd("R8 full after none write", 2'b11);
    rd("R8 none read", 2'b00);

    wr("R5 mode 00 frm 3", 2'b11, 32'h0000_0060);
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) begin
        string t;
        if (c >= NC) t = "R6 class out of range";
        else if (r == 7) t = "R3 dynamic valid";
        else if (r > 4) t = "R4 static reserved";
        else t = "R2 static pass mode 00";
        iss(t, 3'(r), 3'(c));
      end
    end

    for (int f = 0; f < 8; f++) begin
      wr("R3 set stored rounding", 2'b10, 32'(f));
      iss("R3 dynamic select", 3'b111, 3'd0);
      iss("R2 static ignores stored", 3'b001, 3'd1);
    end

    wr("R3 restore rounding", 2'b10, 32'd2);
    for (int a = 0; a < 4; a++) begin
      wr("R5 set accuracy", 2'b11, 32'(a << 8) | 32'h40);
      for (int c = 0; c < NC; c++) begin
        iss("R6 pair support", 3'b000, 3'(c));
        iss("R5 accuracy dynamic rm", 3'b111, 3'(c));
      end
      cyc("R6 no issue no trap", 1'b0, 2'b00, 32'd0, 1'b0, 3'd0, 3'd3, 1'b0, 5'd0);
    end

    wr("R9 clear flags", 2'b01, 32'd0);
    cyc("R9 done first", 1'b0, 2'b01, 32'd0, 1'b0, 3'd0, 3'd0, 1'b1, 5'h01);
    cyc("R9 done second", 1'b0, 2'b01, 32'd0, 1'b0, 3'd0, 3'd0, 1'b1, 5'h04);
    rd("R9 sticky result", 2'b01);
    cyc("R9 flags write with done", 1'b1, 2'b01, 32'h10, 1'b0, 3'd0, 3'd0, 1'b1, 5'h02);
    rd("R9 merged result", 2'b01);
    cyc("R9 full write with done", 1'b1, 2'b11, 32'h0E0, 1'b0, 3'd0, 3'd0, 1'b1, 5'h08);
    rd("R9 full merged", 2'b11);
    cyc("R9 rounding write with done", 1'b1, 2'b10, 32'd2, 1'b0, 3'd0, 3'd0, 1'b1, 5'h01);
    rd("R9 after rounding write", 2'b11);
    cyc("R9 done zero flags", 1'b0, 2'b11, 32'd0, 1'b0, 3'd0, 3'd0, 1'b1, 5'h00);
    rd("R9 unchanged", 2'b11);

    rd("R1 idle", 2'b00);
    repeat (3) @(negedge clk);
    done_run = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule